// File: doc/BRIEF.md
# Register-Controlled Single-Byte SPI Master

This block is an SPI master that moves one byte per command. Software sees two 32-bit registers on a plain memory-mapped bus. The control word is at byte address 0x0. It holds the chip-select levels, a serial-clock divider, a loopback switch and a start bit. The data word is at byte address 0x4. Software first loads the byte to send into the data word. It then writes the control word with the start bit set, and polls the busy flag in the control word until the flag drops. Finally it reads the received byte back from the data word.

The serial clock is made from the block's own clock, which acts as the reference. Each serial-clock phase lasts D+1 reference cycles, where D is the divider field. The chip-select pins are not sequenced by hardware. Each pin is a copy of a control bit, so software frames every exchange itself. In loopback the outgoing serial bit replaces the input pin at the receiver, which lets software check the path without a slave attached.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control word reads 0x0000_0015, all three chip-select pins are 1, the serial clock is 0 and busy (control bit 1) reads 0.
- R2: Chip-select pin n takes the value of control bit 2·n (bits 0, 2, 4) from the cycle after any control write.
- R3: The control word reads back the divider in bits 31:27, loopback in bit 3 and the chip selects in bits 4, 2, 0. Bit 1 shows busy and all other bits read 0.
- R4: A control write with bit 1 set while idle raises busy on the next cycle. Busy then stays high for exactly 16·(D+1) cycles.
- R5: The serial clock idles at 0 and each of its phases lasts D+1 reference cycles, where D is control bits 31:27.
- R6: Data leaves on the output pin most significant bit first, and the pin changes only on falling serial-clock edges.
- R7: The input pin is sampled on rising serial-clock edges, and the 8 samples form the received byte with the first sample as its MSB.
- R8: With control bit 3 set, the received byte equals the transmitted byte whatever the input pin does.
- R9: Reading the data word returns the received byte in bits 7:0 and zeros in bits 31:8.
- R10: A control write with the start bit set while busy does not restart or lengthen the running transfer.
- R11: A data-word write while busy does not change the byte being shifted or the byte received.
- R12: A control write with bit 1 clear updates the fields but starts no transfer and leaves the serial clock idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic rises on it |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Byte address (0x0 control, 0x4 data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cs_level | output | 3 | Chip-select levels copied from control bits 0, 2, 4 |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A divider counter that runs wrong shows up at once in the serial-clock phase widths. It also shows in the busy window, which is checked against 16·(D+1) to the cycle. A wrong edge count or shift direction corrupts the byte the slave model captures, or the byte read back, by the end of the same transfer. A bad register file shows on the chip-select pins one cycle after the write, or in the next read of the control word. Gating faults, where a write during busy leaks through, become visible either as a longer busy window or as a wrong received byte in that transfer.

// File: rtl/spibm_pkg.sv
package spibm_pkg;
   // byte offsets of the two registers
   localparam int CTRL_OFF  = 0;
   localparam int DATA_OFF  = 4;
   // control bit positions that software depends on
   localparam int START_BIT = 1;
   localparam int LOOP_BIT  = 3;

   // position of chip-select n inside the control word
   function automatic int cs_pos(input int n);
      return 2 * n;
   endfunction
endpackage

// File: rtl/spibm_regs.sv
module spibm_regs
   import spibm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3,
   parameter int DIV_W  = 5,
   parameter int CS_N   = 3,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              busy,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic [CS_N-1:0]   cs_q,
   output logic [DIV_W-1:0]  div_q,
   output logic              loop_q,
   output logic              start,
   output logic              data_ld,
   output logic [BYTE_W-1:0] data_in
);
   localparam int DIV_LSB = DATA_W - DIV_W;

   logic ctrl_sel, data_sel;
   logic [CS_N-1:0] cs_new;

   assign ctrl_sel = (bus_addr == ADDR_W'(CTRL_OFF));
   assign data_sel = (bus_addr == ADDR_W'(DATA_OFF));
   assign start    = bus_wr && ctrl_sel && bus_wdata[START_BIT] && !busy;
   assign data_ld  = bus_wr && data_sel && !busy;
   assign data_in  = bus_wdata[BYTE_W-1:0];

   generate
      for (genvar i = 0; i < CS_N; i++) begin : g_cs
         assign cs_new[i] = bus_wdata[cs_pos(i)];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q   <= '1;
         div_q  <= '0;
         loop_q <= 1'b0;
      end else if (bus_wr && ctrl_sel) begin
         cs_q   <= cs_new;
         div_q  <= bus_wdata[DIV_LSB +: DIV_W];
         loop_q <= bus_wdata[LOOP_BIT];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (ctrl_sel) begin
         bus_rdata[DIV_LSB +: DIV_W] = div_q;
         bus_rdata[LOOP_BIT]         = loop_q;
         bus_rdata[START_BIT]        = busy;
         for (int i = 0; i < CS_N; i++) bus_rdata[cs_pos(i)] = cs_q[i];
      end else if (data_sel) begin
         bus_rdata[BYTE_W-1:0] = rx_byte;
      end
   end

   // R2
   cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ctrl_sel) |=> (cs_q == $past(cs_new)));

   // R3
   ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_sel |-> (bus_rdata[0 +: BYTE_W] & ~BYTE_W'(8'h1f)) == '0);
endmodule

// File: rtl/spibm_clkdiv.sv
module spibm_clkdiv #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   // >= keeps the phase finite when the divider shrinks mid-transfer
   assign tick = run && (cnt_q >= div);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || tick) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
   end

   // R5
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));
endmodule

// File: rtl/spibm_shifter.sv
module spibm_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              data_ld,
   input  logic [BYTE_W-1:0] data_in,
   input  logic              tick,
   input  logic              loop_en,
   input  logic              miso,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   output logic [BYTE_W-1:0] shreg
);
   localparam int EDGES = 2 * BYTE_W;
   localparam int EW    = $clog2(EDGES);

   logic [EW-1:0] ecnt_q;
   logic          samp_q;
   logic          rx_in;

   assign mosi  = shreg[BYTE_W-1];
   assign rx_in = loop_en ? mosi : miso;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         sclk   <= 1'b0;
         samp_q <= 1'b0;
         ecnt_q <= '0;
         shreg  <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         sclk   <= 1'b0;
         ecnt_q <= '0;
      end else if (data_ld) begin
         shreg <= data_in;
      end else if (busy && tick) begin
         ecnt_q <= ecnt_q + 1'b1;
         if (!sclk) begin
            sclk   <= 1'b1;
            samp_q <= rx_in;
         end else begin
            sclk  <= 1'b0;
            shreg <= {shreg[BYTE_W-2:0], samp_q};
            if (ecnt_q == EW'(EDGES - 1)) busy <= 1'b0;
         end
      end
   end

   // R5
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   // R5
   sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick && !start) |=> $stable(sclk));

   // R6
   mosi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3,
   parameter int DIV_W  = 5,
   parameter int CS_N   = 3,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [CS_N-1:0]   cs_level,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);
   localparam int DIV_LSB = DATA_W - DIV_W;

   generate
      if (DIV_W < 1 || DIV_LSB <= 2 * (CS_N - 1)) begin : g_bad_div
         $error("divider field overlaps the chip-select bits");
      end
      if (CS_N < 1 || BYTE_W < 2 || BYTE_W > DIV_LSB) begin : g_bad_size
         $error("unsupported chip-select count or byte width");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("address too narrow for the data register offset");
      end
   endgenerate

   logic              busy, start, data_ld, loop_q, tick;
   logic [DIV_W-1:0]  div_q;
   logic [BYTE_W-1:0] data_in, shreg;

   spibm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W),
                .CS_N(CS_N), .BYTE_W(BYTE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
      .rx_byte(shreg), .cs_q(cs_level), .div_q(div_q), .loop_q(loop_q),
      .start(start), .data_ld(data_ld), .data_in(data_in));

   spibm_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick));

   spibm_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .data_ld(data_ld),
      .data_in(data_in), .tick(tick), .loop_en(loop_q), .miso(miso),
      .busy(busy), .sclk(sclk), .mosi(mosi), .shreg(shreg));

   // R4
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   // R11
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(shreg));
endmodule

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic [2:0]  cs_level;
   logic        sclk, mosi, miso;

   int   vec = 0;
   int   bad = 0;
   logic [7:0] slv_byte = 8'h00;
   logic [7:0] mcap = 8'h00;
   logic [2:0] nrise = 3'd0;
   int   hcnt = 0;
   int   last_high = 0;

   always #10 clk = ~clk;

   spi_byte_master u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cs_level(cs_level),
      .sclk(sclk), .mosi(mosi), .miso(miso));

   // slave model: presents its byte MSB first, captures the output pin on rising edges
   assign miso = slv_byte[3'd7 - nrise];
   always @(posedge sclk) begin
      mcap  <= {mcap[6:0], mosi};
      nrise <= nrise + 3'd1;
   end

   // width of the serial-clock high phase, in reference cycles
   always @(negedge clk) begin
      if (sclk) hcnt <= hcnt + 1;
      else if (hcnt != 0) begin
         last_high <= hcnt;
         hcnt <= 0;
      end
   end

   function automatic logic [31:0] exp_ctrl(input int d, input bit lp,
                                           input logic [2:0] cs, input bit bsy);
      return (32'(d) << 27) | (32'(lp) << 3) | (32'(bsy) << 1) |
             32'(cs[0]) | (32'(cs[1]) << 2) | (32'(cs[2]) << 4);
   endfunction

   function automatic int exp_busy(input int d);
      return 16 * (d + 1);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 3'd0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // inj: 0 none, 1 start write during busy, 2 data write during busy
   task automatic xfer(input int d, input bit lp, input logic [2:0] cs,
                       input logic [7:0] tx, input logic [7:0] sb, input int inj);
      logic [31:0] r;
      logic [31:0] cw;
      int n;
      logic [7:0] exp_rx;
      cw = exp_ctrl(d, lp, cs, 1'b0);
      slv_byte = sb;
      wr(3'd4, {24'd0, tx});
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = cw | 32'h2;
      @(negedge clk);
      bus_wr = 1'b0;
      n = 0;
      forever begin
         if (inj != 0 && n == 4) begin
            bus_wr = 1'b1;
            bus_addr = (inj == 1) ? 3'd0 : 3'd4;
            bus_wdata = (inj == 1) ? (cw | 32'h2) : {24'd0, ~tx};
            n++;
            @(negedge clk);
            continue;
         end
         bus_wr = 1'b0;
         rd(3'd0, r);
         if (!r[1]) break;
         n++;
         @(negedge clk);
         if (n > 5000) break;
      end
      exp_rx = lp ? tx : sb;
      // R4 R10 busy window length
      chk(n == exp_busy(d), inj == 1 ? "R10 busy window" : "R4 busy window",
          32'(n), 32'(exp_busy(d)));
      // R5 high phase width
      chk(last_high == d + 1, "R5 sclk phase", 32'(last_high), 32'(d + 1));
      // R6 slave saw the transmitted byte MSB first
      chk(mcap == tx, "R6 mosi byte", {24'd0, mcap}, {24'd0, tx});
      rd(3'd4, r);
      if (lp) chk(r[7:0] == exp_rx, "R8 loopback byte", r, {24'd0, exp_rx});
      else    chk(r[7:0] == exp_rx, inj == 2 ? "R11 rx byte" : "R7 rx byte",
                  r, {24'd0, exp_rx});
      // R9
      chk(r[31:8] == 24'd0, "R9 upper zeros", r, {24'd0, exp_rx});
   endtask

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      rd(3'd0, r);
      chk(r == 32'h15, "R1 ctrl reset", r, 32'h15);
      chk(cs_level == 3'b111 && !sclk, "R1 pins reset", {29'd0, cs_level}, 32'h7);

      // R2: each chip select follows its own bit
      for (int i = 0; i < 3; i++) begin
         logic [2:0] cs;
         cs = 3'b111 & ~(3'b1 << i);
         wr(3'd0, exp_ctrl(0, 0, cs, 0));
         chk(cs_level == cs, "R2 cs level", {29'd0, cs_level}, {29'd0, cs});
      end

      // R3 R12: fields read back, no transfer starts
      wr(3'd0, exp_ctrl(21, 1, 3'b010, 0));
      rd(3'd0, r);
      chk(r == exp_ctrl(21, 1, 3'b010, 0), "R3 ctrl readback", r,
          exp_ctrl(21, 1, 3'b010, 0));
      begin
         bit moved;
         moved = 1'b0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            rd(3'd0, r);
            if (r[1] || sclk) moved = 1'b1;
         end
         chk(!moved, "R12 no transfer", {31'd0, moved}, 32'd0);
      end

      // directed: several dividers with the slave model
      xfer(0, 0, 3'b110, 8'hA5, 8'h3C, 0);
      xfer(1, 0, 3'b101, 8'h01, 8'h80, 0);
      xfer(3, 0, 3'b011, 8'hFF, 8'h00, 0);
      xfer(7, 0, 3'b110, 8'h80, 8'hC3, 0);
      // loopback ignores the pin
      xfer(2, 1, 3'b111, 8'h5A, 8'hFF, 0);
      xfer(0, 1, 3'b111, 8'h00, 8'hFF, 0);
      // writes during busy
      xfer(1, 0, 3'b110, 8'h96, 8'h69, 1);
      xfer(1, 0, 3'b110, 8'h3E, 8'hD1, 2);

      // constrained random
      void'($urandom(32'd1234));
      for (int t = 0; t < 16; t++) begin
         int d;
         logic [7:0] tx, sb;
         d  = int'($urandom % 5);
         tx = 8'($urandom);
         sb = 8'($urandom);
         xfer(d, 1'($urandom), 3'($urandom), tx, sb, 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule